// File: doc/BRIEF.md
# Put-Priority FIFO with Error Pulse

A synchronous first-in first-out store that holds up to `DEPTH` words of `WIDTH` bits. The block always shows its oldest stored word on a registered head output, so no read port and no read-enable timing are needed. It also reports the current fill level and raises a one-cycle error flag whenever a request cannot be served.

A write request (`put_i`) wins over a read request (`get_i`) in the same cycle. When both are high, the read is dropped. A write to a full store or a read from an empty store is a misuse. A misuse only raises `err_o` in the following cycle: the fill level, the head word and the stored contents stay as they were. Storage is a circular buffer. Its read and write pointers wrap modulo `DEPTH`. A synchronous active-high reset clears the pointers, the count, the head register and the flag.

Top module: `pq_fifo_putpri`

## Requirements
- R1: In the first cycle after reset, `count_o` is 0, `err_o` is 0 and `head_o` is 0.
- R2: A write while `count_o` < `DEPTH` raises `count_o` by one in the next cycle and leaves `err_o` at 0.
- R3: A write while `count_o` = `DEPTH` sets `err_o` to 1 in the next cycle. `count_o` and `head_o` stay unchanged, and the written word is discarded, so it never appears at the head later.
- R4: A write while `count_o` = 0 makes `head_o` equal the written word in the next cycle.
- R5: A write while 0 < `count_o` < `DEPTH` leaves `head_o` unchanged in the next cycle.
- R6: A read with `put_i` = 0 while `count_o` > 0 lowers `count_o` by one and leaves `err_o` at 0 in the next cycle. `head_o` then shows the next-oldest word, or keeps its last value when the store becomes empty.
- R7: A read with `put_i` = 0 while `count_o` = 0 sets `err_o` to 1 in the next cycle, and `count_o` and `head_o` stay unchanged.
- R8: When `put_i` and `get_i` are both 1, the block behaves exactly like a write alone, and the read is ignored.
- R9: With `put_i` = 0 and `get_i` = 0, in the next cycle `err_o` is 0 and both `count_o` and `head_o` hold.
- R10: `err_o` is 1 only in the cycle right after a misuse, and in that cycle `count_o` and `head_o` equal their values from the cycle before.
- R11: Words leave the head in the order they were written, including across wrap of the internal pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| put_i | input | 1 | Write request, has priority over a read |
| get_i | input | 1 | Read request, drops the current head |
| data_i | input | WIDTH | Word to store on a write |
| head_o | output | WIDTH | Oldest stored word (registered) |
| count_o | output | $clog2(DEPTH+1) | Current number of stored words |
| err_o | output | 1 | One-cycle flag for a write when full or a read when empty |

## Verification
Every output is a register, so each result of a request made in one cycle is due exactly one rising edge later. That holds for the new count, the error flag and the head word, with no extra latency on any path. The bench drives a request at a falling edge and lets the next rising edge take it. It then compares all three outputs at the following falling edge against a shift-array model that was advanced by the same request. No result is expected later than that single edge. Directed sequences come first, covering full, empty, simultaneous requests and error pulses. A long pseudo-random sweep over the four request combinations on a four-deep instance follows, which walks the fill level between both limits many times and forces the pointers to wrap.

// File: rtl/pq_pkg.sv
package pq_pkg;

    // Operation chosen for the current cycle
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_OVF  = 3'd3,
        OP_UNF  = 3'd4
    } pq_op_e;

endpackage

// File: rtl/pq_decode.sv
module pq_decode
    import pq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          put_i,
    input  logic          get_i,
    input  logic [CW-1:0] count_i,
    output pq_op_e        op_o
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    always_comb begin
        if (put_i) begin
            // write has priority, read is dropped
            op_o = (count_i == FULL) ? OP_OVF : OP_PUSH;
        end else if (get_i) begin
            op_o = (count_i == '0) ? OP_UNF : OP_POP;
        end else begin
            op_o = OP_IDLE;
        end
    end

    // R8: a write with a read pending never yields a read operation
    always_comb begin
        if (put_i) begin
            assert_put_wins_R8: assert (op_o == OP_PUSH || op_o == OP_OVF);
        end
    end

endmodule

// File: rtl/pq_ring.sv
module pq_ring
    import pq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pq_op_e           op_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] peek_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    rnext;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        rnext = wrap_inc(ptr_q.rptr);
        unique case (op_i)
            OP_PUSH: ptr_d.wptr = wrap_inc(ptr_q.wptr);
            OP_POP:  ptr_d.rptr = rnext;
            default: ;
        endcase
        // word that becomes the head after a pop
        peek_o = mem_q[rnext];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && op_i == OP_PUSH) begin
            mem_q[ptr_q.wptr] <= wdata_i;
        end
    end

    // R11: pointers stay inside the ring
    assert_ptr_range_R11: assert property (@(posedge clk) disable iff (rst)
        (ptr_q.wptr <= LAST) && (ptr_q.rptr <= LAST));

    // R3 / R7: a misuse never moves a pointer
    assert_misuse_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_OVF || op_i == OP_UNF) |=> $stable(ptr_q));

endmodule

// File: rtl/pq_fifo_putpri.sv
module pq_fifo_putpri
    import pq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             put_i,
    input  logic             get_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o,
    output logic             err_o
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             err;
        logic [WIDTH-1:0] head;
    } st_t;

    st_t              st_d, st_q;
    pq_op_e           op;
    logic [WIDTH-1:0] peek;

    pq_decode #(.DEPTH(DEPTH), .CW(CW)) decode_i (
        .put_i   (put_i),
        .get_i   (get_i),
        .count_i (st_q.cnt),
        .op_o    (op)
    );

    pq_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) ring_i (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .wdata_i (data_i),
        .peek_o  (peek)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (op)
            OP_PUSH: begin
                st_d.cnt = st_q.cnt + CW'(1);
                if (st_q.cnt == '0) st_d.head = data_i;
            end
            OP_POP: begin
                st_d.cnt = st_q.cnt - CW'(1);
                if (st_q.cnt > CW'(1)) st_d.head = peek;
            end
            OP_OVF, OP_UNF: st_d.err = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.head;
    assign count_o = st_q.cnt;
    assign err_o   = st_q.err;

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (count_o == '0) && !err_o && (head_o == '0));

    assert_push_count_R2: assert property (@(posedge clk) disable iff (rst)
        put_i && count_o < FULL |=> (count_o == $past(count_o) + CW'(1)) && !err_o);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        put_i && count_o == FULL |=> err_o && $stable(count_o) && $stable(head_o));

    assert_head_on_first_R4: assert property (@(posedge clk) disable iff (rst)
        put_i && count_o == '0 |=> head_o == $past(data_i));

    assert_head_kept_R5: assert property (@(posedge clk) disable iff (rst)
        put_i && count_o != '0 && count_o < FULL |=> $stable(head_o));

    assert_pop_count_R6: assert property (@(posedge clk) disable iff (rst)
        !put_i && get_i && count_o != '0 |=> (count_o == $past(count_o) - CW'(1)) && !err_o);

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        !put_i && get_i && count_o == '0 |=> err_o && count_o == '0 && $stable(head_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !put_i && !get_i |=> !err_o && $stable(count_o) && $stable(head_o));

    assert_err_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(count_o) && $stable(head_o));

endmodule

// File: tb/pq_fifo_putpri_tb.sv
module pq_fifo_putpri_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 4;
    localparam int W  = 8;
    localparam int CW = $clog2(D + 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         put_i = 1'b0;
    logic         get_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] head_o;
    logic [CW-1:0] count_o;
    logic         err_o;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model: mq[0] is the oldest word
    int mq [D];
    int m_cnt = 0;
    int m_head = 0;
    int m_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pq_fifo_putpri #(.DEPTH(D), .WIDTH(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .put_i   (put_i),
        .get_i   (get_i),
        .data_i  (data_i),
        .head_o  (head_o),
        .count_o (count_o),
        .err_o   (err_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge act, compare at next falling edge
    task automatic step(input bit p, input bit g, input int d);
        string tag;
        if (p) begin
            if (m_cnt == D)      tag = "R3";
            else if (m_cnt == 0) tag = "R2 R4";
            else                 tag = "R2 R5";
            if (g) tag = {"R8 ", tag};
        end else if (g) begin
            tag = (m_cnt == 0) ? "R7" : "R6 R11";
        end else begin
            tag = "R9";
        end
        put_i  = p;
        get_i  = g;
        data_i = W'(d);
        @(posedge clk);
        @(negedge clk);
        if (p) begin
            if (m_cnt == D) begin
                m_err = 1;
            end else begin
                mq[m_cnt] = d & 255;
                if (m_cnt == 0) m_head = d & 255;
                m_cnt++;
                m_err = 0;
            end
        end else if (g) begin
            if (m_cnt == 0) begin
                m_err = 1;
            end else begin
                for (int i = 0; i < D - 1; i++) mq[i] = mq[i + 1];
                m_cnt--;
                if (m_cnt > 0) m_head = mq[0];
                m_err = 0;
            end
        end else begin
            m_err = 0;
        end
        chk(tag, "count", int'(count_o), m_cnt);
        chk(tag, "err",   int'(err_o),   m_err);
        chk(tag, "head",  int'(head_o),  m_head);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned s;
        for (int i = 0; i < D; i++) mq[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "count", int'(count_o), 0);
        chk("R1", "err",   int'(err_o),   0);
        chk("R1", "head",  int'(head_o),  0);

        // R7 underflow from reset, then R10 pulse ends on idle
        step(0, 1, 0);
        step(0, 0, 0);
        chk("R10", "err after idle", int'(err_o), 0);

        // fill, R4 then R5
        step(1, 0, 8'h11);
        step(1, 0, 8'h22);
        step(1, 1, 8'h33);   // R8: read ignored
        step(1, 0, 8'h44);
        // R3 overflow twice, data discarded
        step(1, 0, 8'hEE);
        step(1, 1, 8'hEF);
        step(0, 0, 0);
        chk("R10", "err after idle", int'(err_o), 0);
        // drain: R6, R11 order, head kept when empty
        repeat (4) step(0, 1, 0);
        chk("R6", "head kept on empty", int'(head_o), 8'h44);
        step(0, 1, 0);       // R7
        step(1, 0, 8'h5A);   // R10 cleared by valid op
        chk("R10", "err after valid write", int'(err_o), 0);
        step(0, 0, 0);       // R9

        // near-exhaustive sweep over the four request combinations
        s = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            int op;
            s  = s * 32'd1103515245 + 32'd12345;
            op = int'((s >> 16) % 4);
            step(op[0], op[1], int'((s >> 8) & 255));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule